// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is one output-compare channel of a small microcontroller timer, reached over an 8-bit register bus. It holds a free-running 16-bit counter that advances once every four clocks. It compares that counter with a 16-bit target held in two byte registers at adjacent addresses. When the counter steps onto the target value, a status flag is raised. An interrupt request is driven while the flag is set and the interrupt is enabled.

Software changes the target one byte at a time. Writing the high byte suspends comparison until the low byte follows, so a half-updated target can never produce a false match. The target bytes, the flag and the clear-handshake state are not touched by reset. The flag is cleared by reading the status register while the flag is set and then writing the low target byte. If a match and that clearing write land in the same cycle, the flag stays set.

Top module: `ocmp_unit`

## Requirements
- R1: Address 2 holds target bits 15:8 and address 3 holds bits 7:0. Both can be read back, and writing either byte leaves the other byte unchanged.
- R2: After reset is released, the counter holds 0xFFFC and increments (wrapping past 0xFFFF to 0x0000) on every fourth clock edge. It therefore holds 0xFFFC+j from edge 4j onward, and a match with that value sets the flag at edge 4j+1.
- R3: When the counter steps onto a value equal to the target while comparison is enabled, status bit 7 (address 1) reads 1.
- R4: irq is 1 exactly while the flag is 1 and the interrupt enable (control address 0, bit 7, reset value 0) is 1.
- R5: A write to the high target byte suspends comparison, so no match sets the flag, until the low target byte is written.
- R6: A write to the low target byte alone leaves comparison enabled.
- R7: Reset leaves the target bytes, the flag and the clear-handshake state unchanged. It returns the counter, the suspend state and the interrupt enable to their defined values.
- R8: A low-byte write clears the flag only if a status read saw the flag set after the previous low-byte write. Without such a read, the flag keeps its value.
- R9: The flag is set at most once per counter value: clearing it while the counter still holds the matching value does not set it again.
- R10: When a match and a clearing low-byte write fall in the same cycle, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, must be released in step with clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read can arm the flag clear) |
| addr | input | 2 | Register address: 0 control, 1 status, 2 target high, 3 target low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a prescale of four, and a reset count of 0xFFFC. The reset count puts the counter within a handful of steps of the 0xFFFF-to-0x0000 wrap, so wrap-around matches are reached in a few dozen cycles. Because every run starts from a known count, the exact match edge is known in advance. This lets the bench place a clearing write on the very cycle of a match, and clear the flag inside the four-cycle window where the counter still holds the matching value.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;
  // register map: control, status, then target bytes most significant first
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam int unsigned       A_TGT  = 2;
  localparam int unsigned       IE_BIT   = 7;
  localparam int unsigned       FLAG_BIT = 7;
endpackage

// File: rtl/ocmp_timebase.sv
module ocmp_timebase #(
  parameter int unsigned CW      = 16,
  parameter int unsigned PRESC   = 4,
  parameter logic [CW-1:0] RST_CNT = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          step
);
  localparam int unsigned PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step_q;
  logic          tick;

  always_comb begin
    tick  = (pre_q == PW'(PRESC - 1));
    pre_d = tick ? '0 : pre_q + 1'b1;
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= RST_CNT;
      step_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      step_q <= tick;
      if (tick) cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign step = step_q;
endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CW-1:0]     tgt,
  output logic              hold,
  output logic              ie,
  output logic              lo_wr
);
  localparam int unsigned NB = CW / BUS_W;

  logic hi_wr;
  logic hold_q, hold_d, hold_en;
  logic ie_q, ie_en;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    logic [BUS_W-1:0] byte_q;
    logic             hit;
    assign hit = wr_en && (addr == ADDR_W'(A_TGT + gi));
    // target bytes carry no reset
    always_ff @(posedge clk) begin
      if (hit) byte_q <= wdata;
    end
    assign tgt[CW-1-BUS_W*gi -: BUS_W] = byte_q;
  end

  always_comb begin
    hi_wr   = wr_en && (addr >= ADDR_W'(A_TGT)) && (addr < ADDR_W'(A_TGT + NB - 1));
    lo_wr   = wr_en && (addr == ADDR_W'(A_TGT + NB - 1));
    hold_en = hi_wr || lo_wr;
    hold_d  = hi_wr && !lo_wr;
    ie_en   = wr_en && (addr == A_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (ie_en)   ie_q   <= wdata[IE_BIT];
    end
  end

  assign hold = hold_q;
  assign ie   = ie_q;
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic stat_rd,
  input  logic lo_wr,
  output logic flag,
  output logic armed
);
  logic flag_q, flag_d, flag_en;
  logic arm_q, arm_d, arm_en;

  always_comb begin
    flag_en = match || (lo_wr && arm_q);
    flag_d  = match;
    arm_en  = lo_wr || (stat_rd && flag_q);
    arm_d   = !lo_wr;
  end

  // flag and handshake state are left alone by reset
  always_ff @(posedge clk) begin
    if (flag_en) flag_q <= flag_d;
    if (arm_en)  arm_q  <= arm_d;
  end

  assign flag  = flag_q;
  assign armed = arm_q;

  // R8
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(lo_wr && arm_q));
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned   CW      = 16,
  parameter int unsigned   PRESC   = 4,
  parameter logic [CW-1:0] RST_CNT = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  localparam int unsigned NB = CW / BUS_W;

  logic [CW-1:0] cnt, tgt;
  logic step, hold, ie, lo_wr, flag, armed, match, stat_rd;

  ocmp_timebase #(.CW(CW), .PRESC(PRESC), .RST_CNT(RST_CNT)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .step(step)
  );

  ocmp_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tgt(tgt), .hold(hold), .ie(ie), .lo_wr(lo_wr)
  );

  ocmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .match(match), .stat_rd(stat_rd),
    .lo_wr(lo_wr), .flag(flag), .armed(armed)
  );

  always_comb begin
    match   = step && !hold && (cnt == tgt);
    stat_rd = rd_en && (addr == A_STAT);
    irq     = flag && ie;
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[IE_BIT]   = ie;
    if (addr == A_STAT) rdata[FLAG_BIT] = flag;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(A_TGT + i)) rdata = tgt[CW-1-BUS_W*i -: BUS_W];
    end
  end

  // R9
  once_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(step));

  // R5
  no_match_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(!hold));

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && lo_wr && armed) |=> flag);

  // R3
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && (cnt == tgt)) |=> flag);
endmodule

// File: tb/ocmp_unit_bench.sv
module ocmp_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc;
  logic [7:0] last_lo;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_HI = 2'd2, A_LO = 2'd3;

  ocmp_unit u_ocmp_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // vector: hi, lo, write hi, write lo, check edge, expected flag, requirement
  localparam int NV = 9;
  localparam logic [30:0] VEC [NV] = '{
    {8'hFF, 8'hFE, 1'b1, 1'b1, 8'd12, 1'b1, 4'd3},  // R3
    {8'hFF, 8'hFE, 1'b1, 1'b1, 8'd8,  1'b0, 4'd2},  // R2 one edge early
    {8'hFF, 8'hFE, 1'b1, 1'b1, 8'd9,  1'b1, 4'd2},  // R2 exact edge
    {8'hFF, 8'hFD, 1'b0, 1'b1, 8'd8,  1'b1, 4'd6},  // R6 low byte alone
    {8'hFF, 8'hFD, 1'b1, 1'b0, 8'd12, 1'b0, 4'd5},  // R5 high byte alone
    {8'hFF, 8'hFD, 1'b1, 1'b1, 8'd12, 1'b1, 4'd5},  // R5 low byte releases
    {8'h00, 8'h01, 1'b1, 1'b1, 8'd20, 1'b0, 4'd2},  // R2 wrap, early
    {8'h00, 8'h01, 1'b1, 1'b1, 8'd21, 1'b1, 4'd2},  // R2 wrap, exact
    {8'h12, 8'h34, 1'b1, 1'b1, 8'd60, 1'b0, 4'd3}   // R3 no match far away
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == A_LO) last_lo = d;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic stat_flag(output logic f);
    logic [7:0] d;
    bus_rd(A_STAT, d);
    f = d[7];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic f;
    last_lo = 8'h00;
    @(negedge clk);
    do_reset();
    // R7 / R4 reset state
    chk("R4 irq after reset", {7'd0, irq}, 8'h00);
    bus_rd(A_CTRL, d);
    chk("R7 control after reset", d, 8'h00);
    // R1 byte access
    bus_wr(A_HI, 8'hAB);
    bus_wr(A_LO, 8'hCD);
    bus_rd(A_HI, d); chk("R1 high byte", d, 8'hAB);
    bus_rd(A_LO, d); chk("R1 low byte", d, 8'hCD);
    do_reset();
    bus_rd(A_HI, d); chk("R7 high byte kept", d, 8'hAB);
    bus_rd(A_LO, d); chk("R7 low byte kept", d, 8'hCD);
    bus_wr(A_LO, 8'h55);
    bus_rd(A_HI, d); chk("R1 high untouched by low write", d, 8'hAB);
    bus_rd(A_LO, d); chk("R1 low updated", d, 8'h55);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [30:0] e;
      e = VEC[v];
      stat_flag(f);
      bus_wr(A_LO, last_lo);
      do_reset();
      if (e[14]) bus_wr(A_HI, e[30:23]);
      if (e[13]) bus_wr(A_LO, e[22:15]);
      wait_to(int'(e[12:5]));
      stat_flag(f);
      chk($sformatf("R%0d vector %0d flag", e[3:0], v), {7'd0, f}, {7'd0, e[4]});
    end

    // R4 and R8 directed
    stat_flag(f);
    bus_wr(A_LO, last_lo);
    do_reset();
    bus_wr(A_HI, 8'hFF);
    bus_wr(A_LO, 8'hFE);
    bus_wr(A_CTRL, 8'h80);
    wait_to(8);
    chk("R4 irq low before match", {7'd0, irq}, 8'h00);
    wait_to(9);
    chk("R4 irq high on match", {7'd0, irq}, 8'h01);
    bus_wr(A_CTRL, 8'h00);
    chk("R4 irq masked", {7'd0, irq}, 8'h00);
    bus_wr(A_CTRL, 8'h80);
    bus_wr(A_LO, 8'hFE);
    chk("R8 low write without read keeps flag", {7'd0, irq}, 8'h01);
    stat_flag(f);
    chk("R8 flag seen by status read", {7'd0, f}, 8'h01);
    bus_wr(A_LO, 8'hFE);
    chk("R8 read then low write clears", {7'd0, irq}, 8'h00);
    bus_wr(A_CTRL, 8'h00);

    // R9 clear inside the hold window
    do_reset();
    bus_wr(A_HI, 8'hFF);
    bus_wr(A_LO, 8'hFE);
    wait_to(9);
    stat_flag(f);
    chk("R9 flag set", {7'd0, f}, 8'h01);
    bus_wr(A_LO, 8'hFE);
    wait_to(14);
    stat_flag(f);
    chk("R9 no second set in same counter value", {7'd0, f}, 8'h00);

    // R10 set and clear in one cycle
    do_reset();
    wait_to(10);
    stat_flag(f);
    chk("R10 setup flag", {7'd0, f}, 8'h01);
    do_reset();
    stat_flag(f);
    chk("R7 flag kept across reset", {7'd0, f}, 8'h01);
    wait_to(8);
    bus_wr(A_LO, 8'hFE);
    wait_to(10);
    stat_flag(f);
    chk("R10 match wins over clear", {7'd0, f}, 8'h01);
    bus_wr(A_LO, 8'hFE);
    stat_flag(f);
    chk("R8 clear after set-wins cycle", {7'd0, f}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule